// File: doc/BRIEF.md
# Serial Controller Interrupt and Modem Loopback Unit

This block holds the raw interrupt status of a serial controller and turns it into six interrupt lines. One line is combined and five are per group: receive, transmit, receive timeout, modem status and error. A mask register selects which raw bits can reach the outputs. A clear register drops raw bits, and pulses on `set_i` from the neighbouring receive, timeout and error logic raise them. Register writes arrive on a single-cycle write port, and a select code names the target register.

In loopback mode the block connects the software-driven modem control bits straight to the modem status flags. It then rebuilds the four modem interrupt bits from the new flags. It also routes transmitted characters and break requests into the receive path, and it discards characters and breaks that arrive from the external receive side. Outside loopback, external characters and breaks pass through to the receive path.

Top module: `serial_irq_loop`

## Requirements
- R1: After reset, the raw status, the mask, the modem flags and the loopback and break state are all zero. All six interrupt outputs are low and `rx_push_o` is low.
- R2: The raw bit positions are RI 0, CTS 1, DCD 2, DSR 3, RX 4, TX 5, RT 6 and errors 7..10. Each output is the OR of (raw AND mask) over its group: combined (all bits), rx (4), tx (5), rt (6), modem (0..3) and error (7..10). An output reflects a change in the cycle after the write or pulse that caused it.
- R3: A mask write (select 3) replaces the whole mask with `wr_data_i[10:0]`.
- R4: A clear write (select 4) clears every raw bit that is set in the written value. A `set_i` pulse on the same bit in the same cycle wins.
- R5: Each bit set in `set_i` sets the matching raw bit on the next edge.
- R6: Every data write (select 0) sets raw bit TX (5), whether or not loopback is on.
- R7: A control write (select 1) with bit 0 (loopback enable) high copies the control bits to the modem flags `modem_o[3:0]`: RI←bit 4 (Out2), CTS←bit 2 (RTS), DCD←bit 3 (Out1), DSR←bit 1 (DTR). This happens even when only the enable bit is set.
- R8: On the update in R7, raw bits 0..3 are first cleared and then equal the new modem flags.
- R9: A control write with bit 0 low turns loopback off and leaves the modem flags and raw bits 0..3 unchanged.
- R10: In loopback, a data write pushes `{1'b0, wr_data_i[7:0]}` on `rx_push_data_o` with `rx_push_o` high for one cycle. Outside loopback, a data write pushes nothing.
- R11: In loopback, a line write (select 2) that takes the break bit (bit 0) from 0 to 1 pushes a break entry `{1'b1, 8'h00}`. A write that keeps the bit at 1, clears it, or happens outside loopback pushes nothing.
- R12: Outside loopback, `ext_valid_i` pushes `{1'b0, ext_data_i}` and `ext_brk_i` pushes a break entry on the next cycle. In loopback, both are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 data, 1 control, 2 line, 3 mask, 4 clear |
| wr_data_i | input | WR_W | Write value |
| set_i | input | 11 | Raw status set pulses |
| ext_valid_i | input | 1 | External received character valid |
| ext_data_i | input | DATA_W | External received character |
| ext_brk_i | input | 1 | External break event |
| irq_any_o | output | 1 | Combined interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rt_o | output | 1 | Receive timeout interrupt |
| irq_ms_o | output | 1 | Modem status interrupt |
| irq_err_o | output | 1 | Error interrupt |
| raw_o | output | 11 | Raw interrupt status |
| modem_o | output | 4 | Modem flags: RI, CTS, DCD, DSR in bits 0..3 |
| rx_push_o | output | 1 | Push into receive buffer |
| rx_push_data_o | output | DATA_W+1 | Pushed entry, top bit marks a break |

## Verification
The bench builds the block with its defaults, DATA_W=8 and WR_W=16. This lets a write reach every raw bit, the full mask and every control bit, and it gives pushed entries a full byte plus a break flag. With those widths, every group of interrupt outputs can be driven alone and together. The bench also covers each modem mirror path, clears that race with sets, and break edges both inside and outside loopback.

// File: rtl/sil_pkg.sv
package sil_pkg;
  localparam int NB      = 11;
  localparam int NGRP    = 6;
  localparam int RI_B    = 0;
  localparam int CTS_B   = 1;
  localparam int DCD_B   = 2;
  localparam int DSR_B   = 3;
  localparam int RX_B    = 4;
  localparam int TX_B    = 5;
  localparam int RT_B    = 6;
  localparam int ERR_LO  = 7;
  localparam int ERR_HI  = 10;
  localparam int CB_LB   = 0;
  localparam int CB_DTR  = 1;
  localparam int CB_RTS  = 2;
  localparam int CB_OUT1 = 3;
  localparam int CB_OUT2 = 4;
  localparam int LB_BRK  = 0;

  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_LINE  = 3'd2,
    SEL_MASK  = 3'd3,
    SEL_CLEAR = 3'd4
  } wr_sel_e;

  // group index: 0 any, 1 rx, 2 tx, 3 rt, 4 modem, 5 error
  function automatic logic [NB-1:0] grp_mask(input int g);
    logic [NB-1:0] m;
    m = '0;
    case (g)
      0: m = '1;
      1: m[RX_B] = 1'b1;
      2: m[TX_B] = 1'b1;
      3: m[RT_B] = 1'b1;
      4: m[DSR_B:RI_B] = '1;
      default: for (int b = ERR_LO; b <= ERR_HI; b++) m[b] = 1'b1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sil_modem.sv
module sil_modem import sil_pkg::*; #(
  parameter int WR_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_we_i,
  input  logic            line_we_i,
  input  logic [WR_W-1:0] wdata_i,
  output logic            lb_o,
  output logic [3:0]      flags_o,
  output logic            ms_upd_o,
  output logic [3:0]      ms_new_o,
  output logic            brk_rise_o
);
  logic brk_q;

  assign ms_upd_o = ctrl_we_i && wdata_i[CB_LB];

  always_comb begin
    ms_new_o        = '0;
    ms_new_o[RI_B]  = wdata_i[CB_OUT2];
    ms_new_o[CTS_B] = wdata_i[CB_RTS];
    ms_new_o[DCD_B] = wdata_i[CB_OUT1];
    ms_new_o[DSR_B] = wdata_i[CB_DTR];
  end

  // break edge only counts when loopback is already on
  assign brk_rise_o = line_we_i && wdata_i[LB_BRK] && !brk_q && lb_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lb_o    <= 1'b0;
      brk_q   <= 1'b0;
      flags_o <= '0;
    end else begin
      if (ctrl_we_i) lb_o <= wdata_i[CB_LB];
      if (line_we_i) brk_q <= wdata_i[LB_BRK];
      if (ms_upd_o)  flags_o <= ms_new_o;
    end
  end
endmodule

// File: rtl/sil_status.sv
module sil_status import sil_pkg::*; #(
  parameter int WR_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NB-1:0]   set_i,
  input  logic            clr_we_i,
  input  logic [WR_W-1:0] clr_val_i,
  input  logic            tx_set_i,
  input  logic            ms_upd_i,
  input  logic [3:0]      ms_new_i,
  output logic [NB-1:0]   raw_o
);
  logic [NB-1:0] raw_d;

  always_comb begin
    raw_d = raw_o;
    if (clr_we_i) raw_d = raw_d & ~clr_val_i[NB-1:0];
    if (ms_upd_i) raw_d[DSR_B:RI_B] = ms_new_i;
    raw_d = raw_d | set_i;
    if (tx_set_i) raw_d[TX_B] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else         raw_o <= raw_d;
  end
endmodule

// File: rtl/sil_combine.sv
module sil_combine import sil_pkg::*; #(
  parameter int WR_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mask_we_i,
  input  logic [WR_W-1:0] wdata_i,
  input  logic [NB-1:0]   raw_i,
  output logic [NGRP-1:0] irq_o
);
  logic [NB-1:0] mask_q;
  logic [NB-1:0] act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i[NB-1:0];
  end

  assign act = raw_i & mask_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [NB-1:0] GM = grp_mask(g);
    assign irq_o[g] = |(act & GM);
  end
endmodule

// File: rtl/sil_inject.sv
module sil_inject #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lb_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              brk_rise_i,
  input  logic              ext_valid_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              ext_brk_i,
  output logic              push_o,
  output logic [DATA_W:0]   push_data_o
);
  localparam logic [DATA_W:0] BRK_ENTRY = {1'b1, {DATA_W{1'b0}}};

  logic            push_d;
  logic [DATA_W:0] data_d;

  always_comb begin
    push_d = 1'b0;
    data_d = '0;
    if (lb_i) begin
      if (tx_we_i) begin
        push_d = 1'b1;
        data_d = {1'b0, tx_data_i};
      end else if (brk_rise_i) begin
        push_d = 1'b1;
        data_d = BRK_ENTRY;
      end
    end else if (ext_brk_i) begin
      push_d = 1'b1;
      data_d = BRK_ENTRY;
    end else if (ext_valid_i) begin
      push_d = 1'b1;
      data_d = {1'b0, ext_data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_o      <= 1'b0;
      push_data_o <= '0;
    end else begin
      push_o      <= push_d;
      push_data_o <= data_d;
    end
  end
endmodule

// File: rtl/serial_irq_loop.sv
module serial_irq_loop import sil_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int WR_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [WR_W-1:0]   wr_data_i,
  input  logic [NB-1:0]     set_i,
  input  logic              ext_valid_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              ext_brk_i,
  output logic              irq_any_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o,
  output logic              irq_rt_o,
  output logic              irq_ms_o,
  output logic              irq_err_o,
  output logic [NB-1:0]     raw_o,
  output logic [3:0]        modem_o,
  output logic              rx_push_o,
  output logic [DATA_W:0]   rx_push_data_o
);
  wr_sel_e         sel;
  logic            we_data, we_ctrl, we_line, we_mask, we_clr;
  logic            lb_w, ms_upd, brk_rise;
  logic [3:0]      ms_new;
  logic [NGRP-1:0] irq;

  assign sel     = wr_sel_e'(wr_sel_i);
  assign we_data = wr_en_i && (sel == SEL_DATA);
  assign we_ctrl = wr_en_i && (sel == SEL_CTRL);
  assign we_line = wr_en_i && (sel == SEL_LINE);
  assign we_mask = wr_en_i && (sel == SEL_MASK);
  assign we_clr  = wr_en_i && (sel == SEL_CLEAR);

  sil_modem #(.WR_W(WR_W)) u_modem (
    .clk_i, .rst_ni,
    .ctrl_we_i (we_ctrl),
    .line_we_i (we_line),
    .wdata_i   (wr_data_i),
    .lb_o      (lb_w),
    .flags_o   (modem_o),
    .ms_upd_o  (ms_upd),
    .ms_new_o  (ms_new),
    .brk_rise_o(brk_rise)
  );

  sil_status #(.WR_W(WR_W)) u_status (
    .clk_i, .rst_ni,
    .set_i    (set_i),
    .clr_we_i (we_clr),
    .clr_val_i(wr_data_i),
    .tx_set_i (we_data),
    .ms_upd_i (ms_upd),
    .ms_new_i (ms_new),
    .raw_o    (raw_o)
  );

  sil_combine #(.WR_W(WR_W)) u_comb (
    .clk_i, .rst_ni,
    .mask_we_i(we_mask),
    .wdata_i  (wr_data_i),
    .raw_i    (raw_o),
    .irq_o    (irq)
  );

  sil_inject #(.DATA_W(DATA_W)) u_inj (
    .clk_i, .rst_ni,
    .lb_i       (lb_w),
    .tx_we_i    (we_data),
    .tx_data_i  (wr_data_i[DATA_W-1:0]),
    .brk_rise_i (brk_rise),
    .ext_valid_i(ext_valid_i),
    .ext_data_i (ext_data_i),
    .ext_brk_i  (ext_brk_i),
    .push_o     (rx_push_o),
    .push_data_o(rx_push_data_o)
  );

  assign irq_any_o = irq[0];
  assign irq_rx_o  = irq[1];
  assign irq_tx_o  = irq[2];
  assign irq_rt_o  = irq[3];
  assign irq_ms_o  = irq[4];
  assign irq_err_o = irq[5];
endmodule

// File: rtl/sil_chk.sv
module sil_chk import sil_pkg::*; #(
  parameter int WR_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [2:0]      wr_sel_i,
  input logic [WR_W-1:0] wr_data_i,
  input logic [NB-1:0]   set_i,
  input logic            lb_w,
  input logic            irq_any_o,
  input logic            irq_rx_o,
  input logic            irq_tx_o,
  input logic            irq_rt_o,
  input logic            irq_ms_o,
  input logic            irq_err_o,
  input logic [NB-1:0]   raw_o,
  input logic [3:0]      modem_o,
  input logic            rx_push_o
);
  // R2
  any_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_rx_o || irq_tx_o || irq_rt_o || irq_ms_o || irq_err_o) |-> irq_any_o);

  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd4 && set_i == '0)
    |=> ((raw_o & $past(wr_data_i[NB-1:0])) == '0));

  // R6
  tx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd0) |=> raw_o[TX_B]);

  // R7
  mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd1 && wr_data_i[CB_LB])
    |=> (modem_o == {$past(wr_data_i[CB_DTR]), $past(wr_data_i[CB_OUT1]),
                     $past(wr_data_i[CB_RTS]), $past(wr_data_i[CB_OUT2])}));

  // R8
  ms_rebuild_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd1 && wr_data_i[CB_LB] && set_i[3:0] == '0)
    |=> (raw_o[3:0] == modem_o));

  // R9
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd1 && !wr_data_i[CB_LB]) |=> $stable(modem_o));

  // R12
  ext_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_w && !wr_en_i) |=> !rx_push_o);
endmodule

bind serial_irq_loop sil_chk #(.WR_W(WR_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .set_i, .lb_w,
  .irq_any_o, .irq_rx_o, .irq_tx_o, .irq_rt_o, .irq_ms_o, .irq_err_o,
  .raw_o, .modem_o, .rx_push_o
);

// File: tb/serial_irq_loop_tb.sv
module serial_irq_loop_tb;
  localparam int DW = 8;
  localparam int WW = 16;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [WW-1:0] wr_data = '0;
  logic [10:0]   set = '0;
  logic          ext_valid = 1'b0;
  logic [DW-1:0] ext_data = '0;
  logic          ext_brk = 1'b0;
  logic irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;
  logic [10:0]   raw;
  logic [3:0]    modem;
  logic          push;
  logic [DW:0]   push_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  serial_irq_loop #(.DATA_W(DW), .WR_W(WW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .set_i(set), .ext_valid_i(ext_valid),
    .ext_data_i(ext_data), .ext_brk_i(ext_brk),
    .irq_any_o(irq_any), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx),
    .irq_rt_o(irq_rt), .irq_ms_o(irq_ms), .irq_err_o(irq_err),
    .raw_o(raw), .modem_o(modem), .rx_push_o(push), .rx_push_data_o(push_data)
  );

  function automatic logic [5:0] irqv();
    return {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_any};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op 0..4 = register write select, op 5 = set_i pulse
  task automatic do_op(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    if (op == 3'd5) set = d[10:0];
    else begin
      wr_en = 1'b1; wr_sel = op; wr_data = d;
    end
    @(negedge clk);
    wr_en = 1'b0; set = '0;
  endtask

  task automatic do_ext(input logic v, input logic b, input logic [7:0] d);
    @(negedge clk);
    ext_valid = v; ext_brk = b; ext_data = d;
    @(negedge clk);
    ext_valid = 1'b0; ext_brk = 1'b0;
  endtask

  // {op, data, expected raw, expected irq {err,ms,rt,tx,rx,any}}
  localparam logic [35:0] VEC [NV] = '{
    {3'd3, 16'h07FF, 11'h000, 6'h00},  // R3
    {3'd0, 16'h0041, 11'h020, 6'h05},  // R6 R2
    {3'd5, 16'h0010, 11'h030, 6'h07},  // R5
    {3'd5, 16'h0080, 11'h0B0, 6'h27},  // R5 R2 error group
    {3'd3, 16'h0010, 11'h0B0, 6'h03},  // R3
    {3'd4, 16'h0010, 11'h0A0, 6'h00},  // R4
    {3'd3, 16'h07FF, 11'h0A0, 6'h25},
    {3'd4, 16'h07FF, 11'h000, 6'h00},  // R4
    {3'd5, 16'h0040, 11'h040, 6'h09},
    {3'd1, 16'h0003, 11'h048, 6'h19},  // R7 DTR->DSR
    {3'd1, 16'h0011, 11'h041, 6'h19},  // R8 Out2->RI, DSR cleared
    {3'd1, 16'h0001, 11'h040, 6'h09},  // R7 enable only
    {3'd1, 16'h001E, 11'h040, 6'h09},  // R9
    {3'd4, 16'h0040, 11'h000, 6'h00},
    {3'd1, 16'h000D, 11'h006, 6'h11},  // R7 RTS->CTS, Out1->DCD
    {3'd4, 16'h0002, 11'h004, 6'h11},
    {3'd5, 16'h0400, 11'h404, 6'h31},
    {3'd3, 16'h0000, 11'h404, 6'h00}
  };

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 raw", raw, 0);
    check("R1 irq", irqv(), 0);
    check("R1 modem", modem, 0);
    check("R1 push", push, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 push after release", push, 0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][35:33], VEC[i][32:17]);
      check($sformatf("R2 vec%0d raw", i), raw, VEC[i][16:6]);
      check($sformatf("R2 vec%0d irq", i), irqv(), VEC[i][5:0]);
      check($sformatf("R10 vec%0d no push", i), push, 0);
    end
    check("R7 flags CTS DCD", modem, 4'h6);

    // loopback on, mask 0, raw 0x404
    do_op(3'd0, 16'h005A);
    check("R10 loop data push", push, 1);
    check("R10 loop data value", push_data, 9'h05A);
    check("R6 tx in loopback", raw, 11'h424);
    do_ext(1'b1, 1'b0, 8'h33);
    check("R12 ext char dropped", push, 0);
    do_ext(1'b0, 1'b1, 8'h00);
    check("R12 ext break dropped", push, 0);
    do_op(3'd2, 16'h0001);
    check("R11 break rise push", push, 1);
    check("R11 break entry", push_data, 9'h100);
    do_op(3'd2, 16'h0001);
    check("R11 break held", push, 0);
    do_op(3'd2, 16'h0000);
    check("R11 break fall", push, 0);

    // R4 set wins over clear in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 16'h0010; set = 11'h010;
    @(negedge clk);
    wr_en = 1'b0; set = '0;
    check("R4 set beats clear", raw, 11'h434);

    do_op(3'd1, 16'h0000);
    check("R9 flags kept", modem, 4'h6);
    check("R9 raw kept", raw, 11'h434);
    do_ext(1'b1, 1'b0, 8'hA5);
    check("R12 ext char push", push, 1);
    check("R12 ext char value", push_data, 9'h0A5);
    do_ext(1'b0, 1'b1, 8'h00);
    check("R12 ext break value", {push, push_data}, 10'h300);
    do_op(3'd4, 16'h0020);
    check("R4 clear tx", raw, 11'h414);
    do_op(3'd0, 16'h0011);
    check("R10 no push outside loopback", push, 0);
    check("R6 tx outside loopback", raw, 11'h434);
    do_op(3'd2, 16'h0001);
    check("R11 no break push outside loopback", push, 0);

    do_op(3'd1, 16'h0019);
    check("R7 flags RI DCD", modem, 4'h5);
    check("R8 modem raw rebuilt", raw, 11'h435);
    do_op(3'd3, 16'h07FF);
    check("R2 all groups", irqv(), 6'h37);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule